// File: doc/BRIEF.md
# Do-Across Value Ring for Lane-Striped Virtual Processors

This block carries loop-carried values between virtual processors that are spread round-robin over a set of lanes. Virtual processor n runs on lane n mod NUM_LANES, and the processors on one lane run one after another, row by row. A value that processor n produces may go only to processor n+1, which sits on the next lane. Each lane therefore owns one outgoing link to its neighbour. Every link is a small FIFO with a valid/ready handshake on both ends, so a sender is held off when the link is full and a receiver waits until data is present.

The link from the last lane goes back to lane 0, and there the receiving processor is one row further on. Processor 0 has no predecessor, so it reads its starting value from a seed port. The final processor, NUM_VPS-1, has no successor, so its value leaves on a result port. Lane 0 and the last lane count their own rows so that they know when to switch between the ring and these external ports. When the last processor's value is accepted, both row counts return to zero and the next strip of iterations starts from a new seed.

Top module: `dax_ring`

## Requirements
- R1: While rst_n is low and for the first cycle after it, every link is empty. recv_valid is low on lanes 1..NUM_LANES-1, send_ready is high on lanes 0..NUM_LANES-2, and both row counts are zero.
- R2: If lane l (l < NUM_LANES-1) has a send accepted at clock edge t, the same data word appears on recv_data of lane l+1 with recv_valid high directly after edge t.
- R3: A receiving lane's recv_valid stays low while its incoming link is empty. While recv_valid is high and recv_ready is low, recv_valid stays high and recv_data stays unchanged.
- R4: Values on each link are delivered in the exact order in which they were accepted.
- R5: Each link holds LINK_DEPTH (default 2) values. With that many stored, the sender's send_ready is low, and no accepted value is ever lost.
- R6: In row 0 of lane 0 (processor 0), recv_valid[0] and recv_data[0] equal seed_valid and seed_data in the same cycle, and seed_ready equals recv_ready[0]. The link from the last lane is not drained during this row.
- R7: In rows 1..NUM_VPS/NUM_LANES-1, lane 0 receives from the last lane's link, and seed_ready is low.
- R8: In the last lane, sends in rows 0..NUM_VPS/NUM_LANES-2 go into the link to lane 0. The send in the final row (processor NUM_VPS-1) goes straight to the result port: result_valid equals send_valid, result_data equals send_data, and send_ready equals result_ready. result_valid is low in every other row.
- R9: After the last row's transfer on lane 0 or on the last lane, that lane's row count returns to 0, so the next strip takes its first value from the seed port again.
- R10: With every send valid and every receiver and the result port ready, each link carries one value per cycle and send_ready never drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| seed_valid | input | 1 | Initial value for processor 0 is present |
| seed_ready | output | 1 | Initial value taken this cycle if seed_valid |
| seed_data | input | DATA_W | Initial loop-carried value |
| send_valid | input | NUM_LANES | Per-lane send request |
| send_ready | output | NUM_LANES | Per-lane send accepted |
| send_data | input | NUM_LANES*DATA_W | Per-lane send words, lane l at bits l*DATA_W upward |
| recv_valid | output | NUM_LANES | Per-lane value available |
| recv_ready | input | NUM_LANES | Per-lane receive request |
| recv_data | output | NUM_LANES*DATA_W | Per-lane received words, lane l at bits l*DATA_W upward |
| result_valid | output | 1 | Value from the final processor is present |
| result_ready | input | 1 | Consumer takes the final value |
| result_data | output | DATA_W | Final loop-carried value |

## Verification
The bench keeps one queue per link and a row count for lane 0 and for the last lane, and compares every output against these on every cycle. It uses four traffic patterns. Full-rate traffic with every side ready separates a bubble-free link from one that loses a cycle per transfer. Dense sends against slow receivers and a slow result consumer fill the links, which shows whether the full-link stall holds and whether order survives a full buffer. Balanced random traffic crosses the strip boundary many times, so the switch between seed, ring and result port is tested repeatedly. Sparse sends with eager receivers keep the links mostly empty, which shows whether receivers stall correctly.

// File: rtl/dax_pkg.sv
`timescale 1ns/1ps
// Shared helpers for the do-across ring.
// Assumes: callers pass positive sizes.
package dax_pkg;
    // Index width for a range of v values, never below one bit.
    function automatic int unsigned idx_width(input int unsigned v);
        return (v > 1) ? $clog2(v) : 1;
    endfunction
endpackage

// File: rtl/dax_link_fifo.sv
`timescale 1ns/1ps
// One neighbour link: a DEPTH-entry FIFO with valid/ready on both sides.
// in_ready is low only when full, so an offered word is never dropped.
// The output comes from storage, so a word shows one cycle after it is pushed.
// Assumes: DEPTH >= 2 for full-rate flow with registered ready.
module dax_link_fifo #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data
);
    localparam int PW = dax_pkg::idx_width(DEPTH);
    localparam int CW = dax_pkg::idx_width(DEPTH + 1);

    logic [DATA_W-1:0] store [DEPTH];
    logic [PW-1:0]     wr_ptr, rd_ptr;
    logic [CW-1:0]     count;
    logic              push, pop;

    // Advance a pointer with wrap at DEPTH.
    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Handshake decode and output view.
    always_comb begin
        in_ready  = (count != CW'(DEPTH));
        out_valid = (count != '0);
        out_data  = store[rd_ptr];
        push      = in_valid && in_ready;
        pop       = out_valid && out_ready;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (push) store[wr_ptr] <= in_data;
    end

    p_stall_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    p_push_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid);
endmodule

// File: rtl/dax_row_counter.sv
`timescale 1ns/1ps
// Tracks which row of the stripe a lane is on; wraps after ROWS steps.
// Assumes: step is high for one cycle per completed transfer.
module dax_row_counter #(
    parameter int ROWS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    output logic first,
    output logic last
);
    localparam int RW = dax_pkg::idx_width(ROWS);

    logic [RW-1:0] row;

    // Row flags.
    always_comb begin
        first = (row == '0);
        last  = (row == RW'(ROWS - 1));
    end

    // Row advance with wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)         row <= '0;
        else if (step)      row <= last ? '0 : row + 1'b1;
    end

    p_row_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        row <= RW'(ROWS - 1));
    p_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        step && last |=> first);
endmodule

// File: rtl/dax_seed_mux.sv
`timescale 1ns/1ps
// Lane 0 receive side. Row 0 (processor 0 of a strip) reads the seed port.
// Later rows read the wrap link from the last lane.
// Assumes: recv handshake is valid/ready, transfer when both high.
module dax_seed_mux #(
    parameter int DATA_W = 16,
    parameter int ROWS   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seed_valid,
    output logic              seed_ready,
    input  logic [DATA_W-1:0] seed_data,
    input  logic              link_valid,
    output logic              link_ready,
    input  logic [DATA_W-1:0] link_data,
    output logic              recv_valid,
    input  logic              recv_ready,
    output logic [DATA_W-1:0] recv_data
);
    logic at_first, at_last, take;

    // Source selection by row.
    always_comb begin
        if (at_first) begin
            recv_valid = seed_valid;
            recv_data  = seed_data;
            seed_ready = recv_ready;
            link_ready = 1'b0;
        end else begin
            recv_valid = link_valid;
            recv_data  = link_data;
            seed_ready = 1'b0;
            link_ready = recv_ready;
        end
        take = recv_valid && recv_ready;
    end

    dax_row_counter #(.ROWS(ROWS)) row_i (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (take),
        .first (at_first),
        .last  (at_last)
    );

    p_seed_only_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        seed_ready |-> !link_ready);
    p_link_idle_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        link_ready |-> !seed_ready);
endmodule

// File: rtl/dax_result_split.sv
`timescale 1ns/1ps
// Last-lane send side. The final row (last processor) goes to the result port.
// Earlier rows go into the wrap link towards lane 0.
// Assumes: send handshake is valid/ready, transfer when both high.
module dax_result_split #(
    parameter int DATA_W = 16,
    parameter int ROWS   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              send_valid,
    output logic              send_ready,
    input  logic [DATA_W-1:0] send_data,
    output logic              link_valid,
    input  logic              link_ready,
    output logic [DATA_W-1:0] link_data,
    output logic              result_valid,
    input  logic              result_ready,
    output logic [DATA_W-1:0] result_data
);
    logic at_first, at_last, sent;

    // Destination selection by row.
    always_comb begin
        link_data   = send_data;
        result_data = send_data;
        if (at_last) begin
            result_valid = send_valid;
            link_valid   = 1'b0;
            send_ready   = result_ready;
        end else begin
            result_valid = 1'b0;
            link_valid   = send_valid;
            send_ready   = link_ready;
        end
        sent = send_valid && send_ready;
    end

    dax_row_counter #(.ROWS(ROWS)) row_i (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (sent),
        .first (at_first),
        .last  (at_last)
    );

    p_result_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(result_valid && link_valid));
endmodule

// File: rtl/dax_ring.sv
`timescale 1ns/1ps
// Do-across ring: lane l sends to lane (l+1) mod NUM_LANES through a FIFO.
// Lane 0 row 0 takes the seed; the last lane's final row drives the result.
// Assumes: NUM_VPS is a multiple of NUM_LANES, NUM_LANES >= 2.
module dax_ring #(
    parameter int NUM_LANES  = 4,
    parameter int NUM_VPS    = 12,
    parameter int DATA_W     = 16,
    parameter int LINK_DEPTH = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          seed_valid,
    output logic                          seed_ready,
    input  logic [DATA_W-1:0]             seed_data,
    input  logic [NUM_LANES-1:0]          send_valid,
    output logic [NUM_LANES-1:0]          send_ready,
    input  logic [NUM_LANES*DATA_W-1:0]   send_data,
    output logic [NUM_LANES-1:0]          recv_valid,
    input  logic [NUM_LANES-1:0]          recv_ready,
    output logic [NUM_LANES*DATA_W-1:0]   recv_data,
    output logic                          result_valid,
    input  logic                          result_ready,
    output logic [DATA_W-1:0]             result_data
);
    localparam int ROWS = NUM_VPS / NUM_LANES;
    localparam int LAST = NUM_LANES - 1;

    logic [NUM_LANES-1:0] lk_in_v, lk_in_r, lk_out_v, lk_out_r;
    logic [DATA_W-1:0]    lk_in_d  [NUM_LANES];
    logic [DATA_W-1:0]    lk_out_d [NUM_LANES];

    initial begin
        a_shape_ok: assert (ROWS * NUM_LANES == NUM_VPS && NUM_LANES >= 2);
    end

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_link
        localparam int DST = (g + 1) % NUM_LANES;

        if (g == LAST) begin : g_exit
            dax_result_split #(.DATA_W(DATA_W), .ROWS(ROWS)) split_i (
                .clk          (clk),
                .rst_n        (rst_n),
                .send_valid   (send_valid[g]),
                .send_ready   (send_ready[g]),
                .send_data    (send_data[g*DATA_W +: DATA_W]),
                .link_valid   (lk_in_v[g]),
                .link_ready   (lk_in_r[g]),
                .link_data    (lk_in_d[g]),
                .result_valid (result_valid),
                .result_ready (result_ready),
                .result_data  (result_data)
            );
        end else begin : g_plain_in
            assign lk_in_v[g]    = send_valid[g];
            assign lk_in_d[g]    = send_data[g*DATA_W +: DATA_W];
            assign send_ready[g] = lk_in_r[g];
        end

        dax_link_fifo #(.DATA_W(DATA_W), .DEPTH(LINK_DEPTH)) fifo_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_valid  (lk_in_v[g]),
            .in_ready  (lk_in_r[g]),
            .in_data   (lk_in_d[g]),
            .out_valid (lk_out_v[g]),
            .out_ready (lk_out_r[g]),
            .out_data  (lk_out_d[g])
        );

        if (DST == 0) begin : g_entry
            dax_seed_mux #(.DATA_W(DATA_W), .ROWS(ROWS)) mux_i (
                .clk        (clk),
                .rst_n      (rst_n),
                .seed_valid (seed_valid),
                .seed_ready (seed_ready),
                .seed_data  (seed_data),
                .link_valid (lk_out_v[g]),
                .link_ready (lk_out_r[g]),
                .link_data  (lk_out_d[g]),
                .recv_valid (recv_valid[0]),
                .recv_ready (recv_ready[0]),
                .recv_data  (recv_data[0 +: DATA_W])
            );
        end else begin : g_plain_out
            assign recv_valid[DST]                 = lk_out_v[g];
            assign recv_data[DST*DATA_W +: DATA_W] = lk_out_d[g];
            assign lk_out_r[g]                     = recv_ready[DST];
        end
    end
endmodule

// File: tb/dax_ring_tb.sv
`timescale 1ns/1ps
// Behavioural queue model of the ring, compared on every clock.
module dax_ring_tb_top;
    localparam int NL = 4;
    localparam int NV = 12;
    localparam int W  = 16;
    localparam int D  = 2;
    localparam int RS = NV / NL;
    localparam int LIMIT = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic seed_valid = 1'b0, seed_ready;
    logic [W-1:0] seed_data = '0;
    logic [NL-1:0] send_valid = '0, send_ready, recv_valid, recv_ready = '0;
    logic [NL*W-1:0] send_data = '0, recv_data;
    logic result_valid, result_ready = 1'b0;
    logic [W-1:0] result_data;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    logic [W-1:0] q [NL][$];
    int row0 = 0, rowl = 0, strips = 0, phase = 0, cyc_in_phase = 0;
    logic [W-1:0] tag_ctr = '0;

    always #10 clk = ~clk;

    dax_ring #(.NUM_LANES(NL), .NUM_VPS(NV), .DATA_W(W), .LINK_DEPTH(D)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .seed_valid(seed_valid), .seed_ready(seed_ready), .seed_data(seed_data),
        .send_valid(send_valid), .send_ready(send_ready), .send_data(send_data),
        .recv_valid(recv_valid), .recv_ready(recv_ready), .recv_data(recv_data),
        .result_valid(result_valid), .result_ready(result_ready), .result_data(result_data)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Drive one cycle of stimulus at the given densities (percent).
    task automatic drive(input int pv, input int pr, input int pres);
        seed_valid   = ($urandom_range(99) < pv);
        seed_data    = W'($urandom);
        result_ready = ($urandom_range(99) < pres);
        for (int l = 0; l < NL; l++) begin
            send_valid[l] = ($urandom_range(99) < pv);
            tag_ctr = tag_ctr + 1'b1;
            send_data[l*W +: W] = tag_ctr;
            recv_ready[l] = ($urandom_range(99) < pr);
        end
    endtask

    // Compare outputs with the model and then advance the model over one edge.
    task automatic run_cycle(input int pv, input int pr, input int pres);
        bit exp_rv [NL];
        bit exp_sr [NL];
        logic [W-1:0] exp_rd;
        int src;
        @(negedge clk);
        drive(pv, pr, pres);
        #1;
        for (int l = 0; l < NL; l++) begin
            src = (l + NL - 1) % NL;
            if (l == 0 && row0 == 0) begin
                exp_rv[l] = seed_valid;
                exp_rd = seed_data;
            end else begin
                exp_rv[l] = (q[src].size() > 0);
                exp_rd = exp_rv[l] ? q[src][0] : '0;
            end
            if (l == 0)
                chk(recv_valid[0] == exp_rv[0], (row0 == 0) ? (strips > 0 ? "R9" : "R6") : "R7",
                    "lane0 recv_valid", recv_valid[0], exp_rv[0]);
            else
                chk(recv_valid[l] == exp_rv[l], (phase == 0 && cyc_in_phase > 2) ? "R10" : "R3",
                    "recv_valid", recv_valid[l], exp_rv[l]);
            if (exp_rv[l])
                chk(recv_data[l*W +: W] == exp_rd,
                    (l == 0) ? ((row0 == 0) ? "R6" : "R7") : ((phase == 1) ? "R4" : "R2"),
                    "recv_data", recv_data[l*W +: W], exp_rd);
            if (l == NL - 1 && rowl == RS - 1) exp_sr[l] = result_ready;
            else exp_sr[l] = (q[l].size() < D);
            chk(send_ready[l] == exp_sr[l],
                (l == NL - 1 && rowl == RS - 1) ? "R8" : ((phase == 0) ? "R10" : "R5"),
                "send_ready", send_ready[l], exp_sr[l]);
        end
        chk(seed_ready == (row0 == 0 && recv_ready[0]), (row0 == 0) ? "R6" : "R7",
            "seed_ready", seed_ready, (row0 == 0 && recv_ready[0]));
        chk(result_valid == (rowl == RS - 1 && send_valid[NL-1]), "R8", "result_valid",
            result_valid, (rowl == RS - 1 && send_valid[NL-1]));
        if (result_valid)
            chk(result_data == send_data[(NL-1)*W +: W], "R8", "result_data",
                result_data, send_data[(NL-1)*W +: W]);
        @(posedge clk);
        // Pops first, on the pre-edge state.
        for (int l = 0; l < NL; l++) begin
            src = (l + NL - 1) % NL;
            if (exp_rv[l] && recv_ready[l]) begin
                if (!(l == 0 && row0 == 0)) void'(q[src].pop_front());
                if (l == 0) begin
                    if (row0 == RS - 1) strips++;
                    row0 = (row0 + 1) % RS;
                end
            end
        end
        for (int l = 0; l < NL; l++) begin
            if (send_valid[l] && exp_sr[l]) begin
                if (l == NL - 1) begin
                    if (rowl != RS - 1) q[l].push_back(send_data[l*W +: W]);
                    rowl = (rowl + 1) % RS;
                end else begin
                    q[l].push_back(send_data[l*W +: W]);
                end
            end
        end
        cyc_in_phase++;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state with idle inputs.
        chk(recv_valid[NL-1:1] == '0, "R1", "recv_valid in reset", recv_valid[NL-1:1], 0);
        chk(send_ready[NL-2:0] == '1, "R1", "send_ready in reset", send_ready[NL-2:0], (1 << (NL-1)) - 1);
        chk(result_valid == 1'b0, "R1", "result_valid in reset", result_valid, 0);
        rst_n = 1'b1;
        #1;
        chk(recv_valid[NL-1:1] == '0, "R1", "recv_valid after reset", recv_valid[NL-1:1], 0);
        phase = 0; cyc_in_phase = 0;
        repeat (60)  run_cycle(100, 100, 100);
        phase = 1; cyc_in_phase = 0;
        repeat (150) run_cycle(90, 20, 30);
        phase = 2; cyc_in_phase = 0;
        repeat (400) run_cycle(50, 50, 50);
        phase = 3; cyc_in_phase = 0;
        repeat (100) run_cycle(20, 90, 90);
        chk(strips > 2, "R9", "strips completed", strips, 3);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        done = 1'b1;
        $finish;
    end

    initial begin
        repeat (LIMIT) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", LIMIT);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule